// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Divider

This block divides one integer by another over many clock cycles and returns both the quotient and the remainder. Operands are 64 bits wide. A narrow mode divides only the low 32 bits of each operand. A signed mode treats the operands as two's-complement values. The core works on magnitudes with the non-restoring method and produces one quotient bit per iteration. Each iteration spends one cycle shifting the partial remainder and one cycle adding or subtracting the divisor. That gives a fixed latency of 133 cycles in full-width mode and 69 cycles in narrow mode.

The owner pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads `quotient` and `remainder`. These result outputs keep their value until the next operation completes. After the iterations, the block runs a remainder correction, a sign fix-up, a narrow-mode extension and a retire step. Division by zero does not trap. It returns a defined result after the same fixed latency.

Top module: `seq_divider`

## Requirements
- R1: In unsigned full-width mode, the results satisfy dividend = quotient * divisor + remainder, with remainder < divisor, for every nonzero divisor.
- R2: In full-width mode (`half_width` = 0), `done` rises exactly 133 clock edges after the edge at which `start` was accepted.
- R3: In narrow mode (`half_width` = 1), `done` rises exactly 69 clock edges after the edge at which `start` was accepted.
- R4: In signed mode (`signed_op` = 1), the quotient magnitude is |dividend| / |divisor|. The quotient is negative when the operand signs differ. The remainder carries the dividend's sign. The most negative value divided by -1 yields the most negative value with remainder 0.
- R5: In narrow mode, bits 63..32 of both operands are ignored. Both results are the 32-bit values sign-extended from bit 31 into bits 63..32, whatever `signed_op` is.
- R6: A zero divisor (the low 32 bits in narrow mode) gives an all-ones quotient. The remainder equals the dividend, taken at the mode's width and extended as in R5. The latency is the normal one for the mode.
- R7: `busy` is high from the cycle after an accepted `start` up to, but not including, the cycle in which `done` is high. `done` is high for exactly one cycle.
- R8: `start` is accepted only when `busy` is low. A `start` pulse, or changes on the operand inputs, while busy have no effect on the running operation or on its timing.
- R9: `quotient` and `remainder` change only in the cycle in which `done` is high, and hold their value otherwise.
- R10: While reset is asserted, `busy`, `done`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| signed_op | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| half_width | input | 1 | 1 = divide the low 32 bits only, 0 = full 64 bits |
| dividend | input | 64 | Dividend, sampled at the accepted start |
| divisor | input | 64 | Divisor, sampled at the accepted start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Quotient of the last completed division |
| remainder | output | 64 | Remainder of the last completed division |

## Verification
The hardest situation to reach is a foreign `start` while a division is running, combined with operand inputs that change mid-operation. A careless design would restart or pick up the new values. The stimulus fires a second `start` with different operands and a different mode partway through a full-width division. It also holds `start` high across a whole operation, so the next division begins on the first idle edge. The per-cycle reference model must then agree on the exact completion edge. The signed corner cases are driven directly: most negative value divided by -1, and negative dividend over a zero divisor. Narrow-mode operands carry junk in their upper halves.

// File: rtl/div_pkg.sv
package div_pkg;

  // Control sequence of one division; order is the execution order.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,    // clear partial remainder
    ST_SHIFT,   // first cycle of an iteration
    ST_ACCUM,   // second cycle of an iteration
    ST_CORR,    // add divisor back if remainder negative
    ST_SIGN,    // apply result signs, divide-by-zero value
    ST_ALIGN,   // narrow-mode sign extension
    ST_RETIRE   // publish results
  } div_state_e;

  // Cycles outside the iteration loop: load, corr, sign, align, retire.
  localparam int unsigned DIV_OVERHEAD = 5;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       half_i,
  output div_state_e state_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned CW   = $clog2(XLEN + 1);

  div_state_e    state_q, state_d;
  logic [CW-1:0] iter_q, iter_d;
  logic          half_q, half_d;
  logic          done_q, done_d;
  logic [CW-1:0] last_iter;
  logic          iter_en;

  assign last_iter = half_q ? CW'(HALF - 1) : CW'(XLEN - 1);

  always_comb begin
    state_d = state_q;
    iter_d  = iter_q;
    half_d  = half_q;
    iter_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD;
          half_d  = half_i;
          iter_d  = '0;
          iter_en = 1'b1;
        end
      end
      ST_LOAD:  state_d = ST_SHIFT;
      ST_SHIFT: state_d = ST_ACCUM;
      ST_ACCUM: begin
        if (iter_q == last_iter) begin
          state_d = ST_CORR;
        end else begin
          state_d = ST_SHIFT;
          iter_d  = iter_q + CW'(1);
          iter_en = 1'b1;
        end
      end
      ST_CORR:   state_d = ST_SIGN;
      ST_SIGN:   state_d = ST_ALIGN;
      ST_ALIGN:  state_d = ST_RETIRE;
      ST_RETIRE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_RETIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (iter_en) begin
        iter_q <= iter_d;
      end
      if (state_q == ST_IDLE) begin
        half_q <= half_d;
      end
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

endmodule

// File: rtl/div_operand.sv
module div_operand #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  input  logic            signed_i,
  input  logic            half_i,
  output logic [XLEN-1:0] a_mag_o,
  output logic [XLEN-1:0] b_mag_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            b_zero_o
);

  localparam int unsigned HALF = XLEN / 2;

  logic [1:0][XLEN-1:0] raw;
  logic [1:0][XLEN-1:0] ext;
  logic [1:0][XLEN-1:0] mag;
  logic [1:0]           neg;

  assign raw[0] = dividend_i;
  assign raw[1] = divisor_i;

  // Same extension and magnitude path for both operands.
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic top_bit;
    always_comb begin
      top_bit = half_i ? raw[g][HALF-1] : raw[g][XLEN-1];
      neg[g]  = signed_i & top_bit;
      if (half_i) begin
        ext[g] = {{HALF{neg[g]}}, raw[g][HALF-1:0]};
      end else begin
        ext[g] = raw[g];
      end
      mag[g] = neg[g] ? (~ext[g] + XLEN'(1)) : ext[g];
    end
  end

  assign a_mag_o  = mag[0];
  assign b_mag_o  = mag[1];
  assign neg_q_o  = neg[0] ^ neg[1];
  assign neg_r_o  = neg[0];
  assign b_zero_o = (ext[1] == '0);

endmodule

// File: rtl/div_core.sv
module div_core
  import div_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  div_state_e      state_i,
  input  logic            load_i,
  input  logic            half_i,
  input  logic [XLEN-1:0] a_mag_i,
  input  logic [XLEN-1:0] b_mag_i,
  input  logic            neg_q_i,
  input  logic            neg_r_i,
  input  logic            b_zero_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);

  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned PW   = XLEN + 2;

  logic [PW-1:0]   p_q, p_d;
  logic [XLEN-1:0] q_q, q_d;
  logic [XLEN-1:0] d_q, d_d;
  logic            psign_q, psign_d;
  logic            half_q, negq_q, negr_q, zero_q;
  logic            reg_en;

  logic          sub;
  logic [PW-1:0] d_ext;
  logic [PW-1:0] sum;

  // One adder serves the iteration step and the final correction.
  assign sub   = (state_i == ST_ACCUM) && !psign_q;
  assign d_ext = {2'b00, d_q};
  assign sum   = p_q + (sub ? ~d_ext : d_ext) + PW'(sub);

  assign reg_en = load_i || (state_i != ST_IDLE);

  always_comb begin
    p_d     = p_q;
    q_d     = q_q;
    d_d     = d_q;
    psign_d = psign_q;
    unique case (state_i)
      ST_IDLE: begin
        if (load_i) begin
          q_d = half_i ? {a_mag_i[HALF-1:0], {HALF{1'b0}}} : a_mag_i;
          d_d = b_mag_i;
        end
      end
      ST_LOAD: begin
        p_d     = '0;
        psign_d = 1'b0;
      end
      ST_SHIFT: begin
        psign_d = p_q[PW-1];
        p_d     = {p_q[PW-2:0], q_q[XLEN-1]};
        q_d     = {q_q[XLEN-2:0], 1'b0};
      end
      ST_ACCUM: begin
        p_d    = sum;
        q_d[0] = ~sum[PW-1];
      end
      ST_CORR: begin
        if (p_q[PW-1]) begin
          p_d = sum;
        end
      end
      ST_SIGN: begin
        if (zero_q) begin
          q_d = '1;
        end else if (negq_q) begin
          q_d = ~q_q + XLEN'(1);
        end
        if (negr_q) begin
          p_d = ~p_q + PW'(1);
        end
      end
      ST_ALIGN: begin
        if (half_q) begin
          q_d = {{HALF{q_q[HALF-1]}}, q_q[HALF-1:0]};
          p_d = {{(PW - HALF){p_q[HALF-1]}}, p_q[HALF-1:0]};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= '0;
      q_q     <= '0;
      d_q     <= '0;
      psign_q <= 1'b0;
      half_q  <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (reg_en) begin
        p_q     <= p_d;
        q_q     <= q_d;
        d_q     <= d_d;
        psign_q <= psign_d;
      end
      if (load_i) begin
        half_q <= half_i;
        negq_q <= neg_q_i;
        negr_q <= neg_r_i;
        zero_q <= b_zero_i;
      end
    end
  end

  assign quo_o = q_q;
  assign rem_o = p_q[XLEN-1:0];

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            signed_op,
  input  logic            half_width,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] quotient,
  output logic [XLEN-1:0] remainder
);

  div_state_e      state;
  logic            load;
  logic [XLEN-1:0] a_mag, b_mag;
  logic            neg_q, neg_r, b_zero;
  logic [XLEN-1:0] core_quo, core_rem;
  logic [XLEN-1:0] quo_q, rem_q;
  logic            retire;

  assign load   = (state == ST_IDLE) && start;
  assign retire = (state == ST_RETIRE);

  div_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .half_i  (half_width),
    .state_o (state),
    .busy_o  (busy),
    .done_o  (done)
  );

  div_operand #(.XLEN(XLEN)) u_opnd (
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .signed_i   (signed_op),
    .half_i     (half_width),
    .a_mag_o    (a_mag),
    .b_mag_o    (b_mag),
    .neg_q_o    (neg_q),
    .neg_r_o    (neg_r),
    .b_zero_o   (b_zero)
  );

  div_core #(.XLEN(XLEN)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .load_i   (load),
    .half_i   (half_width),
    .a_mag_i  (a_mag),
    .b_mag_i  (b_mag),
    .neg_q_i  (neg_q),
    .neg_r_i  (neg_r),
    .b_zero_i (b_zero),
    .quo_o    (core_quo),
    .rem_o    (core_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (retire) begin
      quo_q <= core_quo;
      rem_q <= core_rem;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            half_width,
  input logic [XLEN-1:0] divisor,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] quotient,
  input logic [XLEN-1:0] remainder
);

  localparam int unsigned HALF     = XLEN / 2;
  localparam int unsigned LAT_FULL = 2 * XLEN + 5;
  localparam int unsigned LAT_HALF = XLEN + 5;

  int unsigned cnt_q;
  int unsigned lat_q;
  logic        zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 0;
      lat_q  <= 0;
      zero_q <= 1'b0;
    end else if (start && !busy) begin
      cnt_q  <= 0;
      lat_q  <= half_width ? LAT_HALF : LAT_FULL;
      zero_q <= half_width ? (divisor[HALF-1:0] == '0) : (divisor == '0);
    end else if (busy) begin
      cnt_q <= cnt_q + 1;
    end
  end

  // R2 R3
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q == lat_q));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R6
  zero_quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_q) |-> (quotient == '1));

endmodule

bind seq_divider div_checker #(.XLEN(XLEN)) u_div_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .half_width (half_width),
  .divisor    (divisor),
  .busy       (busy),
  .done       (done),
  .quotient   (quotient),
  .remainder  (remainder)
);

// File: tb/tb_seq_divider.sv
module tb_seq_divider;

  localparam int XLEN  = 64;
  localparam int LAT64 = 2 * XLEN + 5;
  localparam int LAT32 = XLEN + 5;

  logic        clk, rst_n, start, signed_op, half_width;
  logic [63:0] dividend, divisor;
  logic        busy, done;
  logic [63:0] quotient, remainder;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  int          rem_cyc;
  logic        exp_busy, exp_done;
  logic [63:0] exp_q, exp_r, pend_q, pend_r;
  string       next_tag, pend_tag, op_tag, lat_tag;

  seq_divider #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_op(signed_op),
    .half_width(half_width), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  // 250 MHz: 4 ns period
  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [63:0] a, input logic [63:0] b,
                                  input logic sgn, input logic m32,
                                  output logic [63:0] q, output logic [63:0] r);
    logic [63:0] ax, bx, am, bm;
    logic        as, bs;
    if (m32) begin
      as = sgn & a[31];
      bs = sgn & b[31];
      ax = as ? {32'hFFFF_FFFF, a[31:0]} : {32'h0, a[31:0]};
      bx = bs ? {32'hFFFF_FFFF, b[31:0]} : {32'h0, b[31:0]};
    end else begin
      as = sgn & a[63];
      bs = sgn & b[63];
      ax = a;
      bx = b;
    end
    am = as ? -ax : ax;
    bm = bs ? -bx : bx;
    if (bm == 64'h0) begin
      q = '1;
      r = ax;
    end else begin
      q = am / bm;
      r = am % bm;
      if (as ^ bs) q = -q;
      if (as) r = -r;
    end
    if (m32) begin
      q = {{32{q[31]}}, q[31:0]};
      r = {{32{r[31]}}, r[31:0]};
    end
  endfunction

  // Behavioural timing model: countdown from the accepting edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_cyc  = 0;
      exp_busy = 1'b0;
      exp_done = 1'b0;
      exp_q    = '0;
      exp_r    = '0;
      lat_tag  = "R2";
      op_tag   = "R10";
      pend_tag = "R10";
    end else begin
      exp_done = 1'b0;
      if (rem_cyc == 0) begin
        if (start) begin
          ref_div(dividend, divisor, signed_op, half_width, pend_q, pend_r);
          rem_cyc  = half_width ? LAT32 : LAT64;
          lat_tag  = half_width ? "R3" : "R2";
          pend_tag = next_tag;
          exp_busy = 1'b1;
        end
      end else begin
        rem_cyc--;
        if (rem_cyc == 0) begin
          exp_busy = 1'b0;
          exp_done = 1'b1;
          exp_q    = pend_q;
          exp_r    = pend_r;
          op_tag   = pend_tag;
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R7", "busy", 64'(busy), 64'(exp_busy));
      check(lat_tag, "done", 64'(done), 64'(exp_done));
      check(exp_done ? op_tag : "R9", "quotient", quotient, exp_q);
      check(exp_done ? op_tag : "R9", "remainder", remainder, exp_r);
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_op(logic [63:0] a, logic [63:0] b, logic s, logic m, string tag);
    @(negedge clk);
    dividend   = a;
    divisor    = b;
    signed_op  = s;
    half_width = m;
    next_tag   = tag;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat ((m ? LAT32 : LAT64) + 1) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; signed_op = 1'b0; half_width = 1'b0;
    dividend = '0; divisor = '0; next_tag = "R1";
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    check("R10", "busy", 64'(busy), 64'h0);
    check("R10", "done", 64'(done), 64'h0);
    check("R10", "quotient", quotient, 64'h0);
    check("R10", "remainder", remainder, 64'h0);
    rst_n = 1'b1;

    // R1: unsigned full width
    run_op(64'd100, 64'd7, 1'b0, 1'b0, "R1");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, "R1");
    run_op(64'h8000_0000_0000_0001, 64'hC000_0000_0000_0000, 1'b0, 1'b0, "R1");
    run_op(64'd5, 64'd9, 1'b0, 1'b0, "R1");
    run_op(64'd0, 64'd5, 1'b0, 1'b0, "R1");

    // R5: narrow mode, junk in upper halves, extension from bit 31
    run_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007, 1'b0, 1'b1, "R5");
    run_op(64'h0000_0000_FFFF_FFFF, 64'd2, 1'b0, 1'b1, "R5");
    run_op(64'hAAAA_AAAA_8000_0000, 64'h5555_5555_0000_0001, 1'b0, 1'b1, "R5");

    // R4: signed, both widths, including most negative / -1
    run_op(64'(-100), 64'd7, 1'b1, 1'b0, "R4");
    run_op(64'd100, 64'(-7), 1'b1, 1'b0, "R4");
    run_op(64'(-100), 64'(-7), 1'b1, 1'b0, "R4");
    run_op(64'h8000_0000_0000_0000, 64'(-1), 1'b1, 1'b0, "R4");
    run_op(64'(-7), 64'd2, 1'b1, 1'b1, "R4");
    run_op(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b1, "R4");

    // R6: divide by zero
    run_op(64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, 1'b0, "R6");
    run_op(64'(-12345), 64'h0, 1'b1, 1'b0, "R6");
    run_op(64'h0000_0000_8000_0005, 64'hFFFF_0000_0000_0000, 1'b0, 1'b1, "R6");

    // R8: foreign start and changing operands while busy
    @(negedge clk);
    dividend = 64'd1000; divisor = 64'd33; signed_op = 1'b0; half_width = 1'b0;
    next_tag = "R8"; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    dividend = 64'(-9); divisor = 64'd4; signed_op = 1'b1; half_width = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dividend = 64'h0; divisor = 64'h0;
    repeat (LAT64) @(negedge clk);

    // R8: start held high across a whole operation retriggers only when idle
    @(negedge clk);
    dividend = 64'd77; divisor = 64'd5; signed_op = 1'b0; half_width = 1'b1;
    next_tag = "R8"; start = 1'b1;
    repeat (LAT32 + 2) @(negedge clk);
    start = 1'b0;
    repeat (LAT32 + 2) @(negedge clk);

    // R1 R4 R5: mixed patterns
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      logic s, m;
      a = {$urandom, $urandom};
      b = (i % 3 == 0) ? 64'($urandom % 16 + 1) : ({$urandom, $urandom} >> (i % 60));
      s = 1'(i % 2);
      m = 1'((i / 2) % 2);
      run_op(a, b, s, m, s ? "R4" : (m ? "R5" : "R1"));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule